// File: doc/BRIEF.md
# Redirect Flush Controller

This block sits at the retire end of a pipeline whose occupancy is not fixed. It decides, for every completing instruction, whether the result is written or thrown away. Each accepted taken-branch event puts a redirect tag into a small ordered queue and sends the controller into its flushing mode. While flushing, completions are discarded, however many of them arrive. The controller goes back to running only when a completion carries a new-stream marker whose redirect tag matches the oldest pending redirect, and that redirect is the last one pending.

When several redirects are pending, the queue keeps them in order. A marker belonging to an earlier redirect only retires that redirect. It can never release the pipeline on behalf of a later one. Decisions are registered, so each verdict appears on the cycle after its completion. When the queue is full, branch events are held off through a ready signal.

Top module: `redirect_flush_ctrl`

## Requirements
- R1: After reset the controller is running (`flushing`=0), `br_ready`=1 and `res_valid`=0. From then on, `flushing` is 1 exactly when at least one redirect is pending.
- R2: While running, every completion (`cmp_valid`=1) yields `res_valid`=1 and `res_commit`=1 on the next cycle, with `res_id` equal to that completion's `cmp_id`.
- R3: A branch event is accepted when `br_valid`=1 and `br_ready`=1. An accepted branch event makes `flushing`=1 from the next cycle.
- R4: While flushing, any number of completions without a marker (`cmp_marker`=0) are each reported with `res_commit`=0, and the controller stays flushing.
- R5: While flushing with exactly one redirect pending and no branch accepted in that cycle, a completion with `cmp_marker`=1 and `cmp_rtag` equal to the pending tag is reported with `res_commit`=1, and the controller is running from the next cycle.
- R6: While flushing, a marked completion whose `cmp_rtag` differs from the oldest pending tag is discarded and removes no redirect.
- R7: With two or more redirects pending, a marked completion matching the oldest tag removes only that redirect and is discarded. The controller stays flushing until a marker matches each later tag in turn.
- R8: The queue holds DEPTH redirects (4 by default). With DEPTH pending, `br_ready`=0 and a branch event on `br_valid` is not recorded.
- R9: A completion in the same cycle as an accepted branch event is judged against the pending redirects as they stood before that branch.
- R10: While running, a marked completion is committed and has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Taken-branch event present |
| br_tag | input | TAGW | Redirect tag of the taken branch |
| br_ready | output | 1 | Redirect queue can accept an event |
| cmp_valid | input | 1 | An instruction completes this cycle |
| cmp_id | input | IDW | Identifier of the completing instruction |
| cmp_marker | input | 1 | Completing instruction is the first of a new stream |
| cmp_rtag | input | TAGW | Redirect tag carried with the marker |
| res_valid | output | 1 | A verdict is presented |
| res_id | output | IDW | Identifier the verdict refers to |
| res_commit | output | 1 | 1 = write result, 0 = discard |
| flushing | output | 1 | Controller is in flushing mode |

## Verification
A verdict is due on the cycle after its completion is driven. A change of mode or of `br_ready` caused by a branch event or a releasing marker also shows one cycle later. The driver applies inputs on the falling edge and files the expected verdict at that moment. The monitor compares verdicts just after the next rising edge. The mode and ready checks are made at the following falling edge, against the bench's own queue of pending tags.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_FLUSH = 1'b1
  } mode_e;

  // A hit on the last pending redirect releases the pipeline unless a new
  // redirect is being recorded in the same cycle.
  function automatic logic resumes(input logic hit, input logic last_entry,
                                   input logic push);
    return hit && last_entry && !push;
  endfunction

  // Verdict for a completion: write when nothing is pending, or when this
  // completion is the one releasing the pipeline.
  function automatic logic verdict(input logic valid, input logic empty,
                                   input logic resume);
    return valid && (empty || resume);
  endfunction

endpackage

// File: rtl/rfc_redirect_fifo.sv
module rfc_redirect_fifo #(
  parameter int DEPTH = 4,
  parameter int TAGW  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [TAGW-1:0]              tag_i,
  input  logic                         pop_i,
  output logic [TAGW-1:0]              head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic                         last_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [TAGW-1:0] slot_q [DEPTH];
  logic [PW-1:0]   wr_q, rd_q;
  logic [CW-1:0]   cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) slot_q[wr_q] <= tag_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = slot_q[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign last_o  = (cnt_q == CW'(1));

  // R8
  fifo_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q != CW'(DEPTH)));

  // R6
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (cnt_q != '0));

endmodule

// File: rtl/rfc_verdict.sv
module rfc_verdict #(
  parameter int TAGW = 4
) (
  input  logic            cmp_valid_i,
  input  logic            marker_i,
  input  logic [TAGW-1:0] rtag_i,
  input  logic            empty_i,
  input  logic            last_i,
  input  logic [TAGW-1:0] head_i,
  input  logic            push_i,
  output logic            hit_o,
  output logic            resume_o,
  output logic            commit_o
);
  import rfc_pkg::*;

  always_comb begin
    hit_o    = cmp_valid_i && marker_i && !empty_i && (rtag_i == head_i);
    resume_o = resumes(hit_o, last_i, push_i);
    commit_o = verdict(cmp_valid_i, empty_i, resume_o);
  end

endmodule

// File: rtl/rfc_mode_fsm.sv
module rfc_mode_fsm (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_i,
  input  logic           resume_i,
  output rfc_pkg::mode_e mode_o
);
  import rfc_pkg::*;

  mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= MODE_RUN;
    else if (push_i)   mode_q <= MODE_FLUSH;
    else if (resume_i) mode_q <= MODE_RUN;
  end

  assign mode_o = mode_q;

  // R3
  enter_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> (mode_q == MODE_FLUSH));

  // R5
  resume_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_i |=> (mode_q == MODE_RUN));

endmodule

// File: rtl/redirect_flush_ctrl.sv
module redirect_flush_ctrl #(
  parameter int DEPTH = 4,
  parameter int TAGW  = 4,
  parameter int IDW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic [TAGW-1:0] br_tag,
  output logic            br_ready,
  input  logic            cmp_valid,
  input  logic [IDW-1:0]  cmp_id,
  input  logic            cmp_marker,
  input  logic [TAGW-1:0] cmp_rtag,
  output logic            res_valid,
  output logic [IDW-1:0]  res_id,
  output logic            res_commit,
  output logic            flushing
);
  import rfc_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic            push_w, hit_w, resume_w, commit_w;
  logic            full_w, empty_w, last_w;
  logic [TAGW-1:0] head_w;
  logic [CW-1:0]   count_w;
  mode_e           mode_w;

  assign br_ready = !full_w;
  assign push_w   = br_valid && br_ready;

  rfc_redirect_fifo #(.DEPTH(DEPTH), .TAGW(TAGW)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_w),
    .tag_i   (br_tag),
    .pop_i   (hit_w),
    .head_o  (head_w),
    .count_o (count_w),
    .full_o  (full_w),
    .empty_o (empty_w),
    .last_o  (last_w)
  );

  rfc_verdict #(.TAGW(TAGW)) u_verdict (
    .cmp_valid_i (cmp_valid),
    .marker_i    (cmp_marker),
    .rtag_i      (cmp_rtag),
    .empty_i     (empty_w),
    .last_i      (last_w),
    .head_i      (head_w),
    .push_i      (push_w),
    .hit_o       (hit_w),
    .resume_o    (resume_w),
    .commit_o    (commit_w)
  );

  rfc_mode_fsm u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (push_w),
    .resume_i (resume_w),
    .mode_o   (mode_w)
  );

  assign flushing = (mode_w == MODE_FLUSH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_commit <= 1'b0;
      res_id     <= '0;
    end else begin
      res_valid  <= cmp_valid;
      res_commit <= commit_w;
      if (cmp_valid) res_id <= cmp_id;
    end
  end

  // R1
  mode_matches_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushing == (count_w != '0));

  // R2
  run_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !flushing) |=>
      (res_valid && res_commit && res_id == $past(cmp_id)));

  // R4
  flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && flushing && !(cmp_marker && cmp_rtag == head_w)) |=>
      (res_valid && !res_commit && flushing));

  // R7
  early_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_marker && flushing && cmp_rtag == head_w &&
     count_w > CW'(1)) |=> (!res_commit && flushing));

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_ready && !hit_w) |=> (count_w == $past(count_w)));

  // R9
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && push_w && !flushing) |=> (res_commit && flushing));

endmodule

// File: tb/redirect_flush_ctrl_test.sv
module redirect_flush_ctrl_test;
  localparam int DEPTH = 4;
  localparam int TAGW  = 4;
  localparam int IDW   = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            br_valid = 1'b0;
  logic [TAGW-1:0] br_tag = '0;
  logic            br_ready;
  logic            cmp_valid = 1'b0;
  logic [IDW-1:0]  cmp_id = '0;
  logic            cmp_marker = 1'b0;
  logic [TAGW-1:0] cmp_rtag = '0;
  logic            res_valid;
  logic [IDW-1:0]  res_id;
  logic            res_commit;
  logic            flushing;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [IDW-1:0] id;
    logic           commit;
    string          req;
  } exp_t;

  exp_t            expq[$];
  logic [TAGW-1:0] mdl[$];

  always #10 clk = ~clk;

  redirect_flush_ctrl #(.DEPTH(DEPTH), .TAGW(TAGW), .IDW(IDW)) uut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_tag(br_tag),
    .br_ready(br_ready), .cmp_valid(cmp_valid), .cmp_id(cmp_id),
    .cmp_marker(cmp_marker), .cmp_rtag(cmp_rtag), .res_valid(res_valid),
    .res_id(res_id), .res_commit(res_commit), .flushing(flushing)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; mode and ready are checked against the model first.
  task automatic step(input logic bv, input logic [TAGW-1:0] bt,
                      input logic cv, input logic [IDW-1:0] cid,
                      input logic cm, input logic [TAGW-1:0] crt,
                      input string req);
    logic push, commit;
    @(negedge clk);
    chk(flushing == (mdl.size() != 0), req, "flushing",
        int'(flushing), int'(mdl.size() != 0));
    chk(br_ready == (mdl.size() < DEPTH), req, "br_ready",
        int'(br_ready), int'(mdl.size() < DEPTH));
    push = bv && (mdl.size() < DEPTH);
    if (cv) begin
      if (mdl.size() == 0) commit = 1'b1;
      else if (cm && crt == mdl[0]) begin
        commit = (mdl.size() == 1) && !push;
        void'(mdl.pop_front());
      end else commit = 1'b0;
      expq.push_back('{id: cid, commit: commit, req: req});
    end
    if (push) mdl.push_back(bt);
    br_valid = bv; br_tag = bt;
    cmp_valid = cv; cmp_id = cid; cmp_marker = cm; cmp_rtag = crt;
  endtask

  task automatic idle(input string req);
    step(1'b0, '0, 1'b0, '0, 1'b0, '0, req);
  endtask

  // Monitor: verdict is due just after the rising edge following stimulus.
  always @(posedge clk) begin
    #2;
    if (rst_n && res_valid) begin
      if (expq.size() == 0) chk(1'b0, "R2", "unexpected verdict", 1, 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        chk(res_id == e.id, e.req, "res_id", int'(res_id), int'(e.id));
        chk(res_commit == e.commit, e.req, "res_commit",
            int'(res_commit), int'(e.commit));
      end
    end
  end

  initial begin
    #2_000_000;
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(flushing == 1'b0, "R1", "flushing after reset", int'(flushing), 0);
    chk(br_ready == 1'b1, "R1", "br_ready after reset", int'(br_ready), 1);
    chk(res_valid == 1'b0, "R1", "res_valid after reset", int'(res_valid), 0);

    // R2 running commits; R10 marker while running
    step(0, 0, 1, 6'd1, 0, 0, "R2");
    step(0, 0, 1, 6'd2, 0, 0, "R2");
    step(0, 0, 1, 6'd3, 1, 4'd7, "R10");
    step(0, 0, 1, 6'd4, 0, 0, "R10");

    // R3 branch, R4 discards, R6 mismatch, R5 release
    step(1, 4'd3, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 6'd5, 0, 0, "R3");
    step(0, 0, 1, 6'd6, 0, 0, "R4");
    step(0, 0, 1, 6'd7, 0, 0, "R4");
    step(0, 0, 1, 6'd8, 1, 4'd5, "R6");
    step(0, 0, 1, 6'd9, 1, 4'd3, "R5");
    step(0, 0, 1, 6'd10, 0, 0, "R5");

    // R7 two pending redirects
    step(1, 4'd1, 0, 0, 0, 0, "R7");
    step(1, 4'd2, 1, 6'd11, 0, 0, "R7");
    step(0, 0, 1, 6'd12, 1, 4'd2, "R7");
    step(0, 0, 1, 6'd13, 1, 4'd1, "R7");
    step(0, 0, 1, 6'd14, 0, 0, "R7");
    step(0, 0, 1, 6'd15, 1, 4'd2, "R7");
    step(0, 0, 1, 6'd16, 0, 0, "R7");

    // R8 fill the queue, extra event must be ignored
    for (int i = 0; i < DEPTH; i++) step(1, 4'(i + 8), 0, 0, 0, 0, "R8");
    step(1, 4'd15, 0, 0, 0, 0, "R8");
    step(1, 4'd14, 0, 0, 0, 0, "R8");
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, 1, 6'(20 + i), 1, 4'(i + 8), "R8");
    step(0, 0, 1, 6'd30, 0, 0, "R8");

    // R9 completion with branch in the same cycle
    step(1, 4'd4, 1, 6'd31, 0, 0, "R9");
    step(1, 4'd5, 1, 6'd32, 1, 4'd4, "R9");
    step(0, 0, 1, 6'd33, 1, 4'd5, "R9");
    step(0, 0, 1, 6'd34, 0, 0, "R9");

    idle("R2");
    idle("R2");
    idle("R2");
    chk(expq.size() == 0, "R2", "verdicts outstanding", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule